// File: doc/BRIEF.md
# Time-shared first-order delta-sigma converter with CIC decimator

This block is the digital half of a delta-sigma converter built around external comparators. Each analog channel has its own comparator, whose output arrives on one bit of `cmp_in`. It also has a resistor-capacitor node that is charged or discharged by the matching bit of `fb_out`. The block registers the comparator bit and sends that registered bit straight back to the node as a one-bit DAC. When the node sits below the input, the comparator reads 1, the node is pulled up, and the loop settles into a pulse-density stream whose density follows the analog level.

One filter datapath is shared by up to eight channels in strict rotation. In each clock cycle one channel slot is served. That channel's comparator bit is captured, mapped to +1 or -1, and pushed through three integrators. The three integrators belong to that channel only. Once the channel has delivered R bits since its last output, its integrator total passes through three comb stages, which also belong to that channel only. The block then emits one signed sample tagged with the channel number. The decimation ratio R is a power of two set by `LOG2R`.

Top module: `sd_cic_adc`

## Requirements
- R1: A synchronous active-high `rst` clears all filter history, the slot rotation and the outputs. While reset is applied and on the first cycle after it, `smp_valid`, `fb_out` and `smp_data` are all zero. Samples produced after reset are the same as those of a filter that has never seen any input.
- R2: The channel slot starts at 0 after reset and advances by one on every clock edge, wrapping after NCH-1. On each edge, `fb_out[c]` for the slotted channel c takes the value of `cmp_in[c]`. Every other `fb_out` bit holds its value, and `cmp_in` bits of channels not in their slot have no effect.
- R3: A captured 1 counts as +1 and a captured 0 counts as -1. Each sample equals the sum over j of h[j]·x[m-j], where x[m] is the channel's newest input, inputs before reset count as zero, and h is the triple convolution of a length-R run of ones (length 3R-2, h[0]=1).
- R4: `smp_valid` is high for exactly one cycle per R inputs of a channel, namely for input indices m with m mod R = R-1. It is due two clock edges after the edge that captured that input, and `smp_chan` then carries the channel number.
- R5: `smp_data` is two's complement with 2+3·LOG2R bits. A steady stream of ones settles to +R³ and a steady stream of zeros settles to -R³, once 3R-2 inputs have been taken.
- R6: A strictly alternating input settles to exactly 0 after 3R-2 inputs, whatever its starting phase.
- R7: Each channel's samples depend only on that channel's own bits, even when the channels carry different patterns.
- R8: In closed loop with a leaky RC node, the settled samples track R³·(2·level−1) for a normalised analog level between 0 and 1, to within R³/4.
- R9: The integrators wrap in two's complement without corrupting samples. A long run of ones keeps returning +R³ after the integrator totals have exceeded the sample width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | NCH | Comparator result, one bit per channel |
| fb_out | output | NCH | Registered feedback bit driving each channel's RC node |
| smp_valid | output | 1 | One-cycle strobe marking a decimated sample |
| smp_chan | output | CHW | Channel number of the current sample |
| smp_data | output | 2+3·LOG2R | Signed decimated sample |

## Verification
The feedback bit of the slotted channel is due one edge after its comparator bit is presented. The decimated sample built from that bit is due two edges later. The bench drives each input just after a falling edge and samples every output at the next falling edge. Before each check it turns the number of rising edges since reset into the slot index and the per-channel input index. From those it works out whether a strobe is due in that cycle and which channel and value it must carry, so a sample that comes early, late or duplicated is caught in the cycle where it goes wrong.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // number of integrator and comb stages
  localparam int CIC_STAGES = 3;

  // width of a channel index, at least one bit
  function automatic int chan_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sdc_capture.sv
// Slot rotation, oversampling capture flops and feedback drive.
module sdc_capture
  import sdc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int LOG2R = 3,
  localparam int CHW  = chan_bits(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cmp_in,
  output logic [NCH-1:0] fb_q,
  output logic           cap_vld,
  output logic           cap_bit,
  output logic           cap_dump,
  output logic [CHW-1:0] cap_ch
);

  logic [CHW-1:0]   slot;
  logic [LOG2R-1:0] phase;
  logic             last_slot;

  assign last_slot = (slot == CHW'(NCH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot     <= '0;
      phase    <= '0;
      fb_q     <= '0;
      cap_vld  <= 1'b0;
      cap_bit  <= 1'b0;
      cap_dump <= 1'b0;
      cap_ch   <= '0;
    end else begin
      fb_q[slot] <= cmp_in[slot];
      cap_bit    <= cmp_in[slot];
      cap_ch     <= slot;
      cap_vld    <= 1'b1;
      cap_dump   <= &phase;
      if (last_slot) begin
        slot  <= '0;
        phase <= phase + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(slot) < NCH);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    cap_vld && !(int'(cap_ch) == NCH - 1) |-> int'(slot) == int'(cap_ch) + 1);

endmodule

// File: rtl/sdc_integ.sv
// Per-channel integrator cascade, time-shared over the channel slots.
module sdc_integ
  import sdc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int ACC_W = 11,
  localparam int CHW  = chan_bits(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic                    in_bit,
  input  logic                    in_dump,
  input  logic [CHW-1:0]          in_ch,
  output logic                    out_vld,
  output logic [CHW-1:0]          out_ch,
  output logic signed [ACC_W-1:0] out_acc
);

  logic signed [ACC_W-1:0] step;

  // a captured 1 adds one, a captured 0 subtracts one
  assign step = in_bit ? ACC_W'(1) : '1;

  for (genvar g = 0; g < CIC_STAGES; g++) begin : g_stage
    logic signed [ACC_W-1:0] mem [NCH];
    logic signed [ACC_W-1:0] feed;
    logic signed [ACC_W-1:0] nxt;

    if (g == 0) begin : g_head
      assign feed = step;
    end else begin : g_tail
      assign feed = g_stage[g-1].nxt;
    end

    // wraparound is intended; the comb removes it
    assign nxt = mem[in_ch] + feed;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int c = 0; c < NCH; c++) mem[c] <= '0;
      end else if (in_vld) begin
        mem[in_ch] <= nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_ch  <= '0;
      out_acc <= '0;
    end else begin
      out_vld <= in_vld & in_dump;
      out_ch  <= in_ch;
      out_acc <= g_stage[CIC_STAGES-1].nxt;
    end
  end

  // R4
  dump_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld));

endmodule

// File: rtl/sdc_comb.sv
// Per-channel comb cascade at the decimated rate, with output registers.
module sdc_comb
  import sdc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int ACC_W = 11,
  localparam int CHW  = chan_bits(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [CHW-1:0]          in_ch,
  input  logic signed [ACC_W-1:0] in_acc,
  output logic                    out_vld,
  output logic [CHW-1:0]          out_ch,
  output logic signed [ACC_W-1:0] out_data
);

  for (genvar g = 0; g < CIC_STAGES; g++) begin : g_stage
    logic signed [ACC_W-1:0] mem [NCH];
    logic signed [ACC_W-1:0] src;
    logic signed [ACC_W-1:0] diff;

    if (g == 0) begin : g_head
      assign src = in_acc;
    end else begin : g_tail
      assign src = g_stage[g-1].diff;
    end

    assign diff = src - mem[in_ch];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int c = 0; c < NCH; c++) mem[c] <= '0;
      end else if (in_vld) begin
        mem[in_ch] <= src;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_ch   <= '0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_ch   <= in_ch;
        out_data <= g_stage[CIC_STAGES-1].diff;
      end
    end
  end

  // R4
  valid_seq_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld && (int'(out_ch) != NCH - 1) |=>
      out_vld && (int'(out_ch) == int'($past(out_ch)) + 1));

  // R4
  valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld && (int'(out_ch) == NCH - 1) |=> !out_vld);

endmodule

// File: rtl/sd_cic_adc.sv
// Top: capture and feedback, shared integrators, shared combs.
module sd_cic_adc
  import sdc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int LOG2R = 3,
  localparam int CHW  = chan_bits(NCH),
  localparam int ACC_W = 2 + CIC_STAGES * LOG2R
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          cmp_in,
  output logic [NCH-1:0]          fb_out,
  output logic                    smp_valid,
  output logic [CHW-1:0]          smp_chan,
  output logic signed [ACC_W-1:0] smp_data
);

  localparam int FULL = 1 << (CIC_STAGES * LOG2R);

  logic                    cap_vld;
  logic                    cap_bit;
  logic                    cap_dump;
  logic [CHW-1:0]          cap_ch;
  logic                    int_vld;
  logic [CHW-1:0]          int_ch;
  logic signed [ACC_W-1:0] int_acc;

  sdc_capture #(.NCH(NCH), .LOG2R(LOG2R)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .cmp_in   (cmp_in),
    .fb_q     (fb_out),
    .cap_vld  (cap_vld),
    .cap_bit  (cap_bit),
    .cap_dump (cap_dump),
    .cap_ch   (cap_ch)
  );

  sdc_integ #(.NCH(NCH), .ACC_W(ACC_W)) u_integ (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (cap_vld),
    .in_bit  (cap_bit),
    .in_dump (cap_dump),
    .in_ch   (cap_ch),
    .out_vld (int_vld),
    .out_ch  (int_ch),
    .out_acc (int_acc)
  );

  sdc_comb #(.NCH(NCH), .ACC_W(ACC_W)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (int_vld),
    .in_ch    (int_ch),
    .in_acc   (int_acc),
    .out_vld  (smp_valid),
    .out_ch   (smp_chan),
    .out_data (smp_data)
  );

  // R5
  full_scale_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (int'(smp_data) <= FULL) && (int'(smp_data) >= -FULL));

  // R4
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> int'(smp_chan) < NCH);

  // R2
  fb_single_change_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(fb_out ^ $past(fb_out)) <= 1);

endmodule

// File: tb/sd_cic_adc_tb.sv
`timescale 1ns/1ps
module sd_cic_adc_tb;

  localparam int NCH   = 4;
  localparam int LOG2R = 3;
  localparam int R     = 1 << LOG2R;
  localparam int FS    = R * R * R;
  localparam int ACC_W = 2 + 3 * LOG2R;
  localparam int CHW   = 2;
  localparam int HLEN  = 3 * R - 2;
  localparam int NIN   = 96;
  localparam int MAXM  = 128;
  localparam int FSV   = 65536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] cmp_in = '0;
  logic [NCH-1:0] fb_out;
  logic smp_valid;
  logic [CHW-1:0] smp_chan;
  logic signed [ACC_W-1:0] smp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int h [HLEN];
  int xs [NCH][MAXM];
  int vrc [NCH];
  int arc [NCH];
  logic [NCH-1:0] fb_exp;

  always #2 clk = ~clk;

  sd_cic_adc #(.NCH(NCH), .LOG2R(LOG2R)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .cmp_in    (cmp_in),
    .fb_out    (fb_out),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .smp_data  (smp_data)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic int pat(input int mode, input int c, input int m);
    case (mode)
      0: return 1;
      1: return 0;
      2: return (m + c) % 2;
      3: return ((((m * (c + 3)) + (m / 8) * c) % 7) < (c + 2)) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int fir(input int c, input int m);
    int s = 0;
    for (int j = 0; j < HLEN; j++)
      if (j <= m) s += h[j] * ((xs[c][m-j] != 0) ? 1 : -1);
    return s;
  endfunction

  task automatic build_taps();
    int t [HLEN];
    for (int i = 0; i < HLEN; i++) h[i] = (i < R) ? 1 : 0;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < HLEN; i++) begin
        t[i] = 0;
        for (int j = 0; j < R; j++) if (i - j >= 0) t[i] += h[i-j];
      end
      for (int i = 0; i < HLEN; i++) h[i] = t[i];
    end
  endtask

  task automatic check_edge(input int mode, input int e);
    int c, m, exp, tgt, diff;
    bit expv;
    chk(fb_out == fb_exp, "R2 feedback bit", int'(fb_out), int'(fb_exp));
    expv = 1'b0;
    c = 0;
    m = 0;
    if (e >= 2) begin
      c = (e - 2) % NCH;
      m = (e - 2) / NCH;
      expv = ((m % R) == R - 1);
    end
    chk(smp_valid == expv, "R4 valid strobe", int'(smp_valid), int'(expv));
    if (expv && smp_valid) begin
      chk(int'(smp_chan) == c, "R4 channel tag", int'(smp_chan), c);
      exp = fir(c, m);
      if (mode == 3)
        chk(int'(smp_data) == exp, "R7 isolated channel sample", int'(smp_data), exp);
      else
        chk(int'(smp_data) == exp, "R3 sample value", int'(smp_data), exp);
      if (m == R - 1)
        chk(int'(smp_data) == exp, "R1 history cleared", int'(smp_data), exp);
      if (m >= HLEN - 1) begin
        if (mode == 0) chk(int'(smp_data) == FS, "R5 all ones", int'(smp_data), FS);
        if (mode == 0 && m >= 64) chk(int'(smp_data) == FS, "R9 wrapped integrators", int'(smp_data), FS);
        if (mode == 1) chk(int'(smp_data) == -FS, "R5 all zeros", int'(smp_data), -FS);
        if (mode == 2) chk(int'(smp_data) == 0, "R6 alternating", int'(smp_data), 0);
      end
      if (mode == 4 && m >= 48) begin
        tgt = ((2 * arc[c] - FSV) * FS) / FSV;
        diff = int'(smp_data) - tgt;
        if (diff < 0) diff = -diff;
        chk(diff <= FS / 4, "R8 closed-loop tracking", int'(smp_data), tgt);
      end
    end
  endtask

  task automatic run_phase(input int mode);
    int slot, m;
    rst = 1'b1;
    cmp_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(smp_valid == 1'b0, "R1 reset valid", int'(smp_valid), 0);
    chk(fb_out == '0, "R1 reset feedback", int'(fb_out), 0);
    chk(smp_data == '0, "R1 reset data", int'(smp_data), 0);
    rst = 1'b0;
    fb_exp = '0;
    for (int c = 0; c < NCH; c++) vrc[c] = FSV / 2;
    for (int e = 0; e < NCH * NIN + 3; e++) begin
      if (e > 0) check_edge(mode, e - 1);
      slot = e % NCH;
      m = e / NCH;
      if (mode == 4) begin
        for (int c = 0; c < NCH; c++) begin
          if (fb_out[c]) vrc[c] = vrc[c] + ((FSV - vrc[c]) >> 5);
          else vrc[c] = vrc[c] - (vrc[c] >> 5);
          cmp_in[c] = (arc[c] > vrc[c]);
        end
      end else begin
        cmp_in = NCH'((e * 13 + mode * 7) ^ (e >> 2));
        cmp_in[slot] = pat(mode, slot, m) != 0;
      end
      xs[slot][m] = int'(cmp_in[slot]);
      fb_exp[slot] = cmp_in[slot];
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    arc[0] = 9830;
    arc[1] = 22938;
    arc[2] = 39321;
    arc[3] = 55705;
    build_taps();
    for (int mode = 0; mode < 5; mode++) run_phase(mode);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule